// File: doc/BRIEF.md
# Streaming Packet Framing and Stall Monitor

This block is a passive observer placed beside a packet streaming transmit interface. It watches the handshake (`mon_valid`, `mon_ready`), the framing markers (`mon_sop`, `mon_eop`) and the header length field of each packet. It drives nothing back into the interface. It reports five kinds of misbehaviour through sticky flags: a second packet start while a packet is still open, an end marker with no packet open, a framing marker raised while valid is low, a sink that keeps ready low for too long, and a packet whose length is larger than the flow-control credit.

The first error after reset, or after a clear, produces a one-cycle trigger pulse. From that point the block freezes a two-entry record of the most recently completed packets, holding each packet's length and beat count. After an event, debug logic or an embedded analyser can read why the link stopped moving. The stall threshold and the credit limit are run-time settings loaded through a small write port. Reset sets them to defaults.

Top module: `pkt_stream_monitor`

## Requirements
- R1: A beat is transferred on a rising clock edge where `mon_valid` and `mon_ready` are both high. Markers held while `mon_ready` is low count once, at the edge where the transfer happens.
- R2: A transferred beat carrying a start while a packet is open sets `err_flags[0]`. The new start opens a fresh packet.
- R3: A transferred beat carrying an end with no open packet and no start in the same beat sets `err_flags[1]`. This includes a second end after a completed packet. Start and end in one beat form a legal single-beat packet.
- R4: `mon_sop` or `mon_eop` high while `mon_valid` is low sets `err_flags[2]`, whatever the state of `mon_ready`.
- R5: `err_flags[3]` is set when `mon_ready` has been low for more than the stall limit of consecutive cycles. The stall limit resets to 100. The low-cycle count restarts whenever `mon_ready` is high and saturates instead of wrapping.
- R6: `err_flags[4]` is set when the length on a packet's first beat is greater than the credit limit. The credit limit resets to `CREDIT_DEF`. A write on `cfg_wr` loads both limits, and the new values take effect on the following cycle.
- R7: Each flag becomes visible the cycle after its cause and stays set until `clr_errs` is pulsed. The cycle after a clear shows all flags at zero, and a clear wins over an error in the same cycle.
- R8: `trig` pulses high for exactly one cycle, together with the first flag set after reset or a clear. Further errors raise no trigger until the next clear.
- R9: Each completed packet shifts `{length, beat count}` into the history: the newest entry moves into the older slot. `hist_frozen` goes high with the trigger, and from then on the history holds its contents until `clr_errs`.
- R10: After reset all flags, `trig`, `hist_frozen` and every history field read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_errs | input | 1 | Clears flags, re-arms trigger, releases history |
| cfg_wr | input | 1 | Loads both limits |
| cfg_stall_limit | input | CNT_W | Stall limit to load |
| cfg_credit | input | LEN_W | Credit limit to load |
| mon_valid | input | 1 | Observed valid |
| mon_ready | input | 1 | Observed ready |
| mon_sop | input | 1 | Observed start-of-packet |
| mon_eop | input | 1 | Observed end-of-packet |
| mon_len | input | LEN_W | Header length, in credit units |
| err_flags | output | 5 | Sticky flags, bit positions per R2 to R6 |
| trig | output | 1 | One-cycle trigger pulse |
| hist_frozen | output | 1 | History held |
| hist_new_len | output | LEN_W | Length of newest completed packet |
| hist_new_beats | output | BEAT_W | Beats of newest completed packet |
| hist_old_len | output | LEN_W | Length of previous packet |
| hist_old_beats | output | BEAT_W | Beats of previous packet |

## Verification
The properties assume that `clr_errs` and `cfg_wr` are single-cycle strobes driven away from the clock edge. They also assume that the observed signals change only between edges. The stimulus changes inputs one nanosecond after each rising edge and returns every signal to an idle state, with ready high and no markers, before the next edge. Each cycle's stimulus therefore touches exactly one edge. Clears and limit writes come only in idle cycles, so no single-beat stimulus overlaps a strobe unintentionally.

// File: rtl/pkt_mon_pkg.sv
package pkt_mon_pkg;
  localparam int NUM_ERR = 5;
  localparam int E_DUP_SOP    = 0;
  localparam int E_ORPHAN_EOP = 1;
  localparam int E_CTL_IDLE   = 2;
  localparam int E_STALL      = 3;
  localparam int E_LEN_OVER   = 4;
endpackage

// File: rtl/pkt_mon_framing.sv
module pkt_mon_framing #(
  parameter int LEN_W  = 10,
  parameter int BEAT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              ready,
  input  logic              sop,
  input  logic              eop,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  credit,
  output logic              ev_dup,
  output logic              ev_orphan,
  output logic              ev_idle,
  output logic              ev_over,
  output logic              done,
  output logic [LEN_W-1:0]  done_len,
  output logic [BEAT_W-1:0] done_beats
);
  logic              open_q;
  logic [LEN_W-1:0]  cur_len_q;
  logic [BEAT_W-1:0] cur_beats_q;
  logic [BEAT_W-1:0] beats_inc;
  logic              xfer;

  assign xfer      = valid & ready;
  assign beats_inc = (cur_beats_q == {BEAT_W{1'b1}}) ? cur_beats_q : cur_beats_q + 1'b1;

  always_comb begin
    ev_idle    = (sop | eop) & ~valid;
    ev_dup     = xfer & sop & open_q;
    ev_orphan  = xfer & eop & ~sop & ~open_q;
    ev_over    = xfer & sop & (len > credit);
    done       = xfer & eop & (sop | open_q);
    done_len   = sop ? len : cur_len_q;
    done_beats = sop ? BEAT_W'(1) : beats_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      cur_len_q   <= '0;
      cur_beats_q <= '0;
    end else if (xfer) begin
      if (sop) begin
        cur_len_q   <= len;
        cur_beats_q <= BEAT_W'(1);
        open_q      <= ~eop;
      end else if (open_q) begin
        cur_beats_q <= beats_inc;
        if (eop) open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_mon_stall.sv
module pkt_mon_stall #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic [CNT_W-1:0] limit,
  output logic             ev_stall
);
  logic [CNT_W-1:0] low_cnt_q;

  assign ev_stall = ~ready & (low_cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || ready) low_cnt_q <= '0;
    else if (low_cnt_q != {CNT_W{1'b1}}) low_cnt_q <= low_cnt_q + 1'b1;
  end
endmodule

// File: rtl/pkt_mon_hist.sv
module pkt_mon_hist #(
  parameter int REC_W = 16,
  parameter int DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic                   hold,
  input  logic [REC_W-1:0]       rec,
  output logic [DEPTH*REC_W-1:0] slots
);
  logic [REC_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) slot_q[0] <= '0;
    else if (push && !hold) slot_q[0] <= rec;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= '0;
      else if (push && !hold) slot_q[i] <= slot_q[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_out
    assign slots[i*REC_W +: REC_W] = slot_q[i];
  end
endmodule

// File: rtl/pkt_stream_monitor.sv
module pkt_stream_monitor
  import pkt_mon_pkg::*;
#(
  parameter int LEN_W      = 10,
  parameter int CNT_W      = 8,
  parameter int BEAT_W     = 6,
  parameter int STALL_DEF  = 100,
  parameter int CREDIT_DEF = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_errs,
  input  logic                cfg_wr,
  input  logic [CNT_W-1:0]    cfg_stall_limit,
  input  logic [LEN_W-1:0]    cfg_credit,
  input  logic                mon_valid,
  input  logic                mon_ready,
  input  logic                mon_sop,
  input  logic                mon_eop,
  input  logic [LEN_W-1:0]    mon_len,
  output logic [NUM_ERR-1:0]  err_flags,
  output logic                trig,
  output logic                hist_frozen,
  output logic [LEN_W-1:0]    hist_new_len,
  output logic [BEAT_W-1:0]   hist_new_beats,
  output logic [LEN_W-1:0]    hist_old_len,
  output logic [BEAT_W-1:0]   hist_old_beats
);
  localparam int REC_W      = LEN_W + BEAT_W;
  localparam int HIST_DEPTH = 2;

  logic [CNT_W-1:0]  stall_lim_q;
  logic [LEN_W-1:0]  credit_q;
  logic              ev_dup, ev_orphan, ev_idle, ev_over, ev_stall;
  logic              done;
  logic [LEN_W-1:0]  done_len;
  logic [BEAT_W-1:0] done_beats;
  logic [NUM_ERR-1:0] events;
  logic              fired_q;
  logic [HIST_DEPTH*REC_W-1:0] slots;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_lim_q <= CNT_W'(STALL_DEF);
      credit_q    <= LEN_W'(CREDIT_DEF);
    end else if (cfg_wr) begin
      stall_lim_q <= cfg_stall_limit;
      credit_q    <= cfg_credit;
    end
  end

  pkt_mon_framing #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_frame (
    .clk(clk), .rst(rst), .valid(mon_valid), .ready(mon_ready),
    .sop(mon_sop), .eop(mon_eop), .len(mon_len), .credit(credit_q),
    .ev_dup(ev_dup), .ev_orphan(ev_orphan), .ev_idle(ev_idle), .ev_over(ev_over),
    .done(done), .done_len(done_len), .done_beats(done_beats)
  );

  pkt_mon_stall #(.CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst(rst), .ready(mon_ready), .limit(stall_lim_q), .ev_stall(ev_stall)
  );

  pkt_mon_hist #(.REC_W(REC_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst(rst), .push(done), .hold(fired_q),
    .rec({done_beats, done_len}), .slots(slots)
  );

  always_comb begin
    events               = '0;
    events[E_DUP_SOP]    = ev_dup;
    events[E_ORPHAN_EOP] = ev_orphan;
    events[E_CTL_IDLE]   = ev_idle;
    events[E_STALL]      = ev_stall;
    events[E_LEN_OVER]   = ev_over;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_errs) begin
      err_flags <= '0;
      trig      <= 1'b0;
      fired_q   <= 1'b0;
    end else begin
      err_flags <= err_flags | events;
      trig      <= ~fired_q & (|events);
      fired_q   <= fired_q | (|events);
    end
  end

  assign hist_frozen    = fired_q;
  assign hist_new_len   = slots[0 +: LEN_W];
  assign hist_new_beats = slots[LEN_W +: BEAT_W];
  assign hist_old_len   = slots[REC_W +: LEN_W];
  assign hist_old_beats = slots[REC_W+LEN_W +: BEAT_W];
endmodule

// File: rtl/pkt_mon_chk.sv
module pkt_mon_chk #(
  parameter int LEN_W  = 10,
  parameter int BEAT_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_errs,
  input logic              mon_valid,
  input logic              mon_sop,
  input logic              mon_eop,
  input logic [4:0]        err_flags,
  input logic              trig,
  input logic              hist_frozen,
  input logic [LEN_W-1:0]  hist_new_len,
  input logic [BEAT_W-1:0] hist_new_beats,
  input logic [LEN_W-1:0]  hist_old_len,
  input logic [BEAT_W-1:0] hist_old_beats
);
  assert_ctl_idle_R4: assert property (@(posedge clk) disable iff (rst)
    ((mon_sop || mon_eop) && !mon_valid && !clr_errs) |=> err_flags[2]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_errs |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_errs |=> (err_flags == 5'd0));

  assert_trig_single_R8: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  assert_trig_flag_R8: assert property (@(posedge clk) disable iff (rst)
    trig |-> (err_flags != 5'd0));

  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hist_frozen && !clr_errs) |=> ($stable(hist_new_len) && $stable(hist_new_beats)
                                    && $stable(hist_old_len) && $stable(hist_old_beats)));
endmodule

bind pkt_stream_monitor pkt_mon_chk #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/sim_pkt_stream_monitor.sv
module sim_pkt_stream_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_errs = 1'b0, cfg_wr = 1'b0;
  logic [7:0] cfg_stall_limit = '0;
  logic [9:0] cfg_credit = '0;
  logic       mon_valid = 1'b0, mon_ready = 1'b1, mon_sop = 1'b0, mon_eop = 1'b0;
  logic [9:0] mon_len = '0;
  logic [4:0] err_flags;
  logic       trig, hist_frozen;
  logic [9:0] hist_new_len, hist_old_len;
  logic [5:0] hist_new_beats, hist_old_beats;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  pkt_stream_monitor u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mon_valid = 1'b0; mon_ready = 1'b1; mon_sop = 1'b0; mon_eop = 1'b0; mon_len = '0;
    clr_errs = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic cyc(input bit v, input bit r, input bit s, input bit e, input int l);
    mon_valid = v; mon_ready = r; mon_sop = s; mon_eop = e; mon_len = 10'(l);
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic clear();
    clr_errs = 1'b1;
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic set_cfg(input int st, input int cr);
    cfg_wr = 1'b1; cfg_stall_limit = 8'(st); cfg_credit = 10'(cr);
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10 reset state
    chk("R10 flags", int'(err_flags), 0);
    chk("R10 trig", int'(trig), 0);
    chk("R10 frozen", int'(hist_frozen), 0);
    chk("R10 hist", int'(hist_new_len) + int'(hist_new_beats) + int'(hist_old_len) + int'(hist_old_beats), 0);

    // R5 default stall limit of 100
    for (int i = 0; i < 100; i++) cyc(0, 0, 0, 0, 0);
    chk("R5 default 100 low", int'(err_flags[3]), 0);
    cyc(0, 0, 0, 0, 0);
    chk("R5 default 101 low", int'(err_flags[3]), 1);
    chk("R8 trig on first", int'(trig), 1);
    cyc(0, 1, 0, 0, 0);
    chk("R8 trig one cycle", int'(trig), 0);
    chk("R7 sticky", int'(err_flags[3]), 1);
    clear();
    chk("R7 cleared", int'(err_flags), 0);

    // R5 limit sweep, with a ready-high break restarting the count
    for (int lim = 1; lim <= 6; lim++) begin
      set_cfg(lim, 64);
      for (int k = 0; k < lim; k++) cyc(0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0);
      for (int k = 0; k < lim; k++) cyc(0, 0, 0, 0, 0);
      chk("R5 at limit", int'(err_flags[3]), 0);
      cyc(0, 0, 0, 0, 0);
      chk("R5 over limit", int'(err_flags[3]), 1);
      clear();
    end
    set_cfg(100, 20);

    // R6 length sweep against credit 20 (bit 4)
    for (int l = 0; l <= 40; l++) begin
      cyc(1, 1, 1, 1, l);
      chk("R6 len vs credit", int'(err_flags[4]), (l > 20) ? 1 : 0);
      clear();
    end

    // R9 history capture
    cyc(1, 1, 1, 0, 7); cyc(1, 1, 0, 0, 0); cyc(1, 1, 0, 1, 0);
    cyc(1, 1, 1, 1, 4);
    chk("R9 new len", int'(hist_new_len), 4);
    chk("R9 new beats", int'(hist_new_beats), 1);
    chk("R9 old len", int'(hist_old_len), 7);
    chk("R9 old beats", int'(hist_old_beats), 3);
    chk("R3 single beat legal", int'(err_flags), 0);

    // R1 start held while ready low counts once
    cyc(1, 0, 1, 0, 9); cyc(1, 0, 1, 0, 9); cyc(1, 1, 1, 0, 9);
    cyc(1, 1, 0, 1, 0);
    chk("R1 held start once", int'(err_flags), 0);
    chk("R1 beats", int'(hist_new_beats), 2);
    chk("R1 len", int'(hist_new_len), 9);

    // R3 double end, freeze history (R9)
    cyc(1, 1, 0, 1, 0);
    chk("R3 orphan end", int'(err_flags[1]), 1);
    chk("R9 frozen", int'(hist_frozen), 1);
    cyc(1, 1, 0, 1, 0);
    chk("R8 no second trig", int'(trig), 0);
    cyc(1, 1, 1, 1, 3);
    chk("R9 hold new", int'(hist_new_len), 9);
    chk("R9 hold old", int'(hist_old_len), 4);
    clear();
    cyc(1, 1, 1, 1, 3);
    chk("R9 resume new", int'(hist_new_len), 3);
    chk("R9 resume old", int'(hist_old_len), 9);

    // R2 duplicate start restarts packet
    cyc(1, 1, 1, 0, 5); cyc(1, 1, 1, 0, 6);
    chk("R2 dup start", int'(err_flags[0]), 1);
    chk("R2 only bit0", int'(err_flags), 1);
    clear();
    cyc(1, 1, 0, 1, 0);
    chk("R2 restart closes", int'(err_flags), 0);
    chk("R2 restart len", int'(hist_new_len), 6);
    chk("R2 restart beats", int'(hist_new_beats), 2);

    // R4 markers with valid low
    cyc(0, 1, 1, 0, 0);
    chk("R4 start no valid", int'(err_flags), 4);
    clear();
    cyc(0, 0, 0, 1, 0);
    chk("R4 end no valid", int'(err_flags), 4);
    clear();

    // R7 clear wins over same-cycle event
    clr_errs = 1'b1; mon_valid = 1'b0; mon_sop = 1'b1;
    @(posedge clk); #1; idle_inputs();
    chk("R7 clear priority", int'(err_flags), 0);
    chk("R7 no trig", int'(trig), 0);

    // R6 credit takes effect after write
    set_cfg(100, 5);
    cyc(1, 1, 1, 1, 6);
    chk("R6 new credit", int'(err_flags[4]), 1);
    clear();
    cyc(1, 1, 1, 1, 5);
    chk("R6 equal credit", int'(err_flags[4]), 0);

    finish_run();
  end
endmodule